// File: doc/BRIEF.md
# Indexed Interrupt Redirection Unit

This block takes a set of external interrupt pins and turns each pin event into a delivery message for the processor side. Each pin owns a 64-bit redirection entry. The entry holds the vector, delivery mode, destination mode, 8-bit destination, pin polarity, trigger mode and mask. Software reaches the identity word, the version word, the arbitration word and every entry through two byte offsets. An index register picks a 32-bit word, and a data window reads or writes the word that was picked.

Each pin passes through a two-flop synchronizer and then through its polarity inversion. Each entry is a small state machine with three states:

- `ENT_IDLE`: the entry waits for a trigger.
- `ENT_PENDING`: a message waits to be taken. This state is the delivery-status bit.
- `ENT_AWAIT_EOI`: a level-triggered message has been taken. This state is the remote-IRR bit.

The transitions are named as follows:

- `trigger` (IDLE to PENDING): an unmasked rising edge in edge mode, or an unmasked active level in level mode.
- `cancel` (PENDING to IDLE): the entry is masked, or a level pin drops, before the message is taken.
- `send_edge` (PENDING to IDLE): the message of an edge-mode entry is taken.
- `send_level` (PENDING to AWAIT_EOI): the message of a level-mode entry is taken.
- `eoi_match` (AWAIT_EOI to IDLE): an end-of-interrupt arrives whose vector equals the entry's vector.

The NMI and INIT delivery modes always count as edge mode. A fixed-priority picker offers the lowest-numbered requesting entry on a valid/ready message port. The transport of messages to processors and any arbitration between processors are outside this block.

Top module: `intr_redirect`

## Requirements
- R1: Byte offset 0x00 is the 8-bit index register and byte offset 0x10 is the data window; any other offset reads 0 and ignores writes.
  - Window word 0 is the identity word, with a writable 4-bit ID in bits 27:24.
  - Window word 1 is the version word: bits 7:0 hold VERSION (default 0x11), bits 23:16 hold NUM_PINS-1, and the word is read-only.
  - Window word 2 is the arbitration word, which reads the ID in bits 27:24 and is read-only.
- R2: Entry n is reached at index 0x10+2n (low word) and 0x10+2n+1 (high word).
  - The low word holds: vector in 7:0, delivery mode in 10:8 (100 = NMI, 101 = INIT), destination mode in 11, delivery status in 12, polarity in 13 (1 = active low), remote IRR in 14, trigger in 15 (1 = level) and mask in 16.
  - Bits 12 and 14 are read-only, and bits 31:17 read 0.
  - The high word holds the destination in bits 31:24, and its other bits read 0.
  - Any index at or above 0x10+2·NUM_PINS, or in 3..0x0F, reads 0.
- R3: After reset, every entry is masked with all other fields 0, the index and ID are 0, and no message is offered.
- R4: Each pin passes through a two-flop synchronizer and then its polarity.
  - An edge-mode entry is triggered by an inactive-to-active transition of the synchronized, polarized signal. Holding the pin active does not trigger it again.
  - The offered message carries the entry's vector, delivery mode, destination mode and destination, and a level flag that is 1 only for an effective level-mode entry.
- R5: Delivery status reads 1 from the cycle after the trigger until the message is taken (msg_valid and msg_ready high at a clock edge) or the request is cancelled.
- R6: When several entries request at once, the lowest-numbered one is offered, and only that one is taken on a handshake.
- R7: A masked entry ignores edges, and such an edge is lost when the entry is later unmasked. Masking a pending entry cancels its request.
- R8: A level-mode entry requests while its polarized pin is active, and a request whose pin goes inactive before it is taken is withdrawn. Once its message is taken, remote IRR reads 1 and the entry sends nothing more, even with the pin still active.
- R9: An end-of-interrupt clears remote IRR in every entry awaiting one whose vector equals the end-of-interrupt vector. An end-of-interrupt with any other vector has no effect.
- R10: A level-mode entry whose pin is still active when its remote IRR clears requests and is delivered again.
- R11: Delivery modes NMI (100) and INIT (101) behave as edge mode even when bit 15 is 1. They never set remote IRR and offer the message with the level flag 0.
- R12: An end-of-interrupt that arrives in the same cycle in which a level-mode message with the same vector is taken does not clear the remote IRR that this handshake sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the register access |
| acc_addr | input | 8 | Byte offset (0x00 index, 0x10 window) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, combinational |
| irq_pin | input | NUM_PINS | Asynchronous interrupt pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| msg_valid | output | 1 | A delivery message is offered |
| msg_ready | input | 1 | The transport takes the offered message |
| msg_vector | output | 8 | Message vector (0 when not valid) |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_dest | output | 8 | Message destination |
| msg_level | output | 1 | Message is level-triggered |

## Verification
An end-of-interrupt can arrive in the same cycle as the handshake that takes a level message with the same vector. A dedicated scenario drives msg_ready and eoi_valid together for one clock on a pending level entry, then reads remote IRR back through the window and expects it to be 1. A configuration write that masks an entry can also land in the cycle its request is offered. The long random phase provokes both coincidences many times, and the behavioural model in the bench judges every message field and every window read on each clock.

// File: rtl/intr_redirect_pkg.sv
package intr_redirect_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE      = 2'd0,
        ENT_PENDING   = 2'd1,
        ENT_AWAIT_EOI = 2'd2
    } ent_state_t;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level_trig;
        logic       active_low;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vector;
    } ent_cfg_t;

    localparam logic [2:0] MODE_NMI  = 3'b100;
    localparam logic [2:0] MODE_INIT = 3'b101;

    // NMI and INIT are forced to edge behaviour whatever the trigger bit says
    function automatic logic is_level_mode(input ent_cfg_t c);
        return c.level_trig && (c.mode != MODE_NMI) && (c.mode != MODE_INIT);
    endfunction

endpackage

// File: rtl/intr_pin_sync.sv
module intr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic active_low,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_raw};
            prev_q  <= lvl;
        end
    end

    assign lvl  = chain_q[STAGES-1] ^ active_low;
    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/intr_route_entry.sv
module intr_route_entry
    import intr_redirect_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        lvl,
    input  logic        rise,
    input  logic        grant,
    input  logic        eoi_valid,
    input  logic [7:0]  eoi_vector,
    output ent_cfg_t    cfg,
    output logic        req,
    output logic        pending,
    output logic        remote_irr
);
    ent_state_t state_q, state_d;
    ent_cfg_t   cfg_q;
    logic       lvl_mode;
    logic       eoi_hit;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[23:17], wdata[14], wdata[12]};
    assign lvl_mode     = is_level_mode(cfg_q);
    assign eoi_hit      = eoi_valid && (eoi_vector == cfg_q.vector);

    // configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mask <= 1'b1;
        end else begin
            if (wr_lo) begin
                cfg_q.vector     <= wdata[7:0];
                cfg_q.mode       <= wdata[10:8];
                cfg_q.logical    <= wdata[11];
                cfg_q.active_low <= wdata[13];
                cfg_q.level_trig <= wdata[15];
                cfg_q.mask       <= wdata[16];
            end
            if (wr_hi) begin
                cfg_q.dest <= wdata[31:24];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENT_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE: begin
                if (!cfg_q.mask && (lvl_mode ? lvl : rise)) state_d = ENT_PENDING;      // trigger
            end
            ENT_PENDING: begin
                if (grant)     state_d = lvl_mode ? ENT_AWAIT_EOI : ENT_IDLE;           // send_level / send_edge
                else if (!req) state_d = ENT_IDLE;                                       // cancel
            end
            ENT_AWAIT_EOI: begin
                if (eoi_hit) state_d = ENT_IDLE;                                         // eoi_match
            end
            default: state_d = ENT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cfg        = cfg_q;
        pending    = (state_q == ENT_PENDING);
        remote_irr = (state_q == ENT_AWAIT_EOI);
        req        = pending && !cfg_q.mask && (!lvl_mode || lvl);
    end

    assert_grant_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> state_q != ENT_PENDING);

    assert_masked_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_IDLE && cfg_q.mask) |=> state_q == ENT_IDLE);

    assert_await_from_level_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ENT_AWAIT_EOI) |-> ($past(grant) && $past(lvl_mode)));

    assert_await_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_AWAIT_EOI && !eoi_hit) |=> state_q == ENT_AWAIT_EOI);

    assert_eoi_same_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && lvl_mode && eoi_hit) |=> state_q == ENT_AWAIT_EOI);

endmodule

// File: rtl/intr_pick_lowest.sv
module intr_pick_lowest #(
    parameter int N     = 24,
    parameter int SEL_W = 5
) (
    input  logic [N-1:0]     req,
    input  logic             ready,
    output logic             any,
    output logic [SEL_W-1:0] sel,
    output logic [N-1:0]     grant
);
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) sel = SEL_W'(i);
        end
    end

    assign any = |req;

    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (ready && any && (sel == SEL_W'(i))) grant[i] = 1'b1;
        end
    end

endmodule

// File: rtl/intr_redirect.sv
module intr_redirect
    import intr_redirect_pkg::*;
#(
    parameter int         NUM_PINS    = 24,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] VERSION     = 8'h11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic [7:0]          acc_addr,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         acc_rdata,
    input  logic [NUM_PINS-1:0] irq_pin,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic                msg_logical,
    output logic [7:0]          msg_dest,
    output logic                msg_level
);
    localparam logic [7:0] OFS_INDEX    = 8'h00;
    localparam logic [7:0] OFS_WINDOW   = 8'h10;
    localparam logic [7:0] IDX_ID       = 8'h00;
    localparam logic [7:0] IDX_VER      = 8'h01;
    localparam logic [7:0] IDX_ARB      = 8'h02;
    localparam logic [7:0] IDX_ENT_BASE = 8'h10;
    localparam int         ENT_LIMIT    = 16 + 2 * NUM_PINS;
    localparam int         SEL_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [7:0] MAX_ENTRY    = 8'(NUM_PINS - 1);

    logic [7:0]          index_q;
    logic [3:0]          id_q;
    logic                win_hit;
    logic                in_range;
    logic [7:0]          ent_num;
    logic [NUM_PINS-1:0] wr_lo, wr_hi;
    logic [NUM_PINS-1:0] pin_lvl, pin_rise;
    logic [NUM_PINS-1:0] req, pend, rirr, grant;
    ent_cfg_t            cfg [NUM_PINS];
    logic [SEL_W-1:0]    sel;
    logic                any_req;
    logic [31:0]         ent_lo, ent_hi, win_rd;

    assign win_hit  = (acc_addr == OFS_WINDOW);
    assign in_range = (index_q >= IDX_ENT_BASE) && (int'(index_q) < ENT_LIMIT);
    assign ent_num  = (index_q - IDX_ENT_BASE) >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            id_q    <= '0;
        end else if (acc_wr) begin
            if (acc_addr == OFS_INDEX) index_q <= acc_wdata[7:0];
            if (win_hit && index_q == IDX_ID) id_q <= acc_wdata[27:24];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        assign wr_lo[i] = acc_wr && win_hit && in_range && (ent_num == 8'(i)) && !index_q[0];
        assign wr_hi[i] = acc_wr && win_hit && in_range && (ent_num == 8'(i)) &&  index_q[0];

        intr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_raw    (irq_pin[i]),
            .active_low (cfg[i].active_low),
            .lvl        (pin_lvl[i]),
            .rise       (pin_rise[i])
        );

        intr_route_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (wr_lo[i]),
            .wr_hi      (wr_hi[i]),
            .wdata      (acc_wdata),
            .lvl        (pin_lvl[i]),
            .rise       (pin_rise[i]),
            .grant      (grant[i]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .cfg        (cfg[i]),
            .req        (req[i]),
            .pending    (pend[i]),
            .remote_irr (rirr[i])
        );
    end

    intr_pick_lowest #(.N(NUM_PINS), .SEL_W(SEL_W)) u_pick (
        .req   (req),
        .ready (msg_ready),
        .any   (any_req),
        .sel   (sel),
        .grant (grant)
    );

    // entry word read-back
    always_comb begin
        ent_lo = '0;
        ent_hi = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (ent_num == 8'(i)) begin
                ent_lo = {15'b0, cfg[i].mask, cfg[i].level_trig, rirr[i], cfg[i].active_low,
                          pend[i], cfg[i].logical, cfg[i].mode, cfg[i].vector};
                ent_hi = {cfg[i].dest, 24'b0};
            end
        end
    end

    always_comb begin
        win_rd = '0;
        if (index_q == IDX_ID || index_q == IDX_ARB) win_rd = {4'b0, id_q, 24'b0};
        else if (index_q == IDX_VER)                 win_rd = {8'b0, MAX_ENTRY, 8'b0, VERSION};
        else if (in_range)                           win_rd = index_q[0] ? ent_hi : ent_lo;
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_addr == OFS_INDEX) acc_rdata = {24'b0, index_q};
        else if (win_hit)          acc_rdata = win_rd;
    end

    // message mux
    always_comb begin
        msg_valid   = any_req;
        msg_vector  = '0;
        msg_mode    = '0;
        msg_logical = 1'b0;
        msg_dest    = '0;
        msg_level   = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (any_req && sel == SEL_W'(i)) begin
                msg_vector  = cfg[i].vector;
                msg_mode    = cfg[i].mode;
                msg_logical = cfg[i].logical;
                msg_dest    = cfg[i].dest;
                msg_level   = is_level_mode(cfg[i]);
            end
        end
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_needs_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (msg_valid && msg_ready));

endmodule

// File: tb/intr_redirect_tb_top.sv
module intr_redirect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_wr = 1'b0;
    logic [7:0]    acc_addr = '0;
    logic [31:0]   acc_wdata = '0;
    logic [31:0]   acc_rdata;
    logic [NP-1:0] irq_pin = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_vector;
    logic [2:0]    msg_mode;
    logic          msg_logical;
    logic [7:0]    msg_dest;
    logic          msg_level;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_redirect #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_pin(irq_pin),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_level(msg_level)
    );

    // ---------------- behavioural reference model ----------------
    int         m_state [NP];   // 0 idle, 1 pending, 2 awaiting EOI
    bit         m_s1 [NP], m_s2 [NP], m_prev [NP];
    bit         m_pol [NP], m_trig [NP], m_mask [NP], m_log [NP];
    logic [7:0] m_vec [NP], m_dest [NP];
    logic [2:0] m_mode [NP];
    logic [7:0] m_index;
    logic [3:0] m_id;

    function automatic bit m_lvl(int i);
        return m_s2[i] ^ m_pol[i];
    endfunction
    function automatic bit m_islevel(int i);
        return m_trig[i] && m_mode[i] != 3'd4 && m_mode[i] != 3'd5;
    endfunction
    function automatic bit m_req(int i);
        return m_state[i] == 1 && !m_mask[i] && (!m_islevel(i) || m_lvl(i));
    endfunction
    function automatic int m_pick();
        for (int i = 0; i < NP; i++) if (m_req(i)) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_state[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
                m_pol[i] = 0; m_trig[i] = 0; m_mask[i] = 1; m_log[i] = 0;
                m_vec[i] = 0; m_dest[i] = 0; m_mode[i] = 0;
            end
            m_index = 0; m_id = 0;
        end else begin
            int g;
            int ns [NP];
            g = msg_ready ? m_pick() : -1;
            for (int i = 0; i < NP; i++) begin
                ns[i] = m_state[i];
                case (m_state[i])
                    0: if (!m_mask[i] && (m_islevel(i) ? m_lvl(i) : (m_lvl(i) && !m_prev[i]))) ns[i] = 1;
                    1: if (g == i) ns[i] = m_islevel(i) ? 2 : 0;
                       else if (!m_req(i)) ns[i] = 0;
                    default: if (eoi_valid && eoi_vector == m_vec[i]) ns[i] = 0;
                endcase
            end
            for (int i = 0; i < NP; i++) begin
                m_state[i] = ns[i];
                m_prev[i]  = m_lvl(i);
                m_s2[i]    = m_s1[i];
                m_s1[i]    = irq_pin[i];
            end
            if (acc_wr) begin
                if (acc_addr == 8'h00) m_index = acc_wdata[7:0];
                else if (acc_addr == 8'h10) begin
                    if (m_index == 8'h00) m_id = acc_wdata[27:24];
                    else if (m_index >= 8'h10 && int'(m_index) < 16 + 2 * NP) begin
                        int n;
                        n = (int'(m_index) - 16) / 2;
                        if (m_index[0]) m_dest[n] = acc_wdata[31:24];
                        else begin
                            m_vec[n] = acc_wdata[7:0]; m_mode[n] = acc_wdata[10:8];
                            m_log[n] = acc_wdata[11]; m_pol[n] = acc_wdata[13];
                            m_trig[n] = acc_wdata[15]; m_mask[n] = acc_wdata[16];
                        end
                    end
                end
            end
        end
    end

    function automatic logic [31:0] m_rdata();
        if (acc_addr == 8'h00) return {24'b0, m_index};
        if (acc_addr != 8'h10) return 32'h0;
        if (m_index == 8'h00 || m_index == 8'h02) return {4'b0, m_id, 24'b0};
        if (m_index == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        if (m_index >= 8'h10 && int'(m_index) < 16 + 2 * NP) begin
            int n;
            n = (int'(m_index) - 16) / 2;
            if (m_index[0]) return {m_dest[n], 24'b0};
            return {15'b0, m_mask[n], m_trig[n], m_state[n] == 2, m_pol[n],
                    m_state[n] == 1, m_log[n], m_mode[n], m_vec[n]};
        end
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int p;
            p = m_pick();
            check((acc_addr == 8'h10 && m_index >= 8'h10) ? "R2 window entry word" : "R1 register read",
                  acc_rdata, m_rdata());
            check("R6 msg_valid", {31'b0, msg_valid}, {31'b0, p >= 0});
            if (p >= 0)
                check("R4 message fields", {8'b0, msg_vector, msg_dest, 3'b0, msg_mode, msg_logical, msg_level},
                      {8'b0, m_vec[p], m_dest[p], 3'b0, m_mode[p], m_log[p], m_islevel(p)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        tick();
        acc_wr = 1'b0; acc_addr = 8'h00;
    endtask

    task automatic wr_entry(input int n, input bit hi, input logic [31:0] d);
        wr(8'h00, 8'(16 + 2 * n + (hi ? 1 : 0)));
        wr(8'h10, d);
    endtask

    task automatic rd_index(input logic [7:0] idx, input logic [7:0] a, output logic [31:0] v);
        wr(8'h00, idx);
        acc_addr = a;
        @(negedge clk);
        v = acc_rdata;
        tick();
        acc_addr = 8'h00;
    endtask

    task automatic rd_entry(input int n, input bit hi, output logic [31:0] v);
        rd_index(8'(16 + 2 * n + (hi ? 1 : 0)), 8'h10, v);
    endtask

    task automatic peek_valid(input string tag, input bit exp);
        @(negedge clk);
        check(tag, {31'b0, msg_valid}, {31'b0, exp});
        tick();
    endtask

    task automatic peek_msg(input string tag, input logic [7:0] vec, input bit lvl);
        @(negedge clk);
        check(tag, {22'b0, msg_valid, msg_level, msg_vector}, {22'b0, 1'b1, lvl, vec});
        tick();
    endtask

    task automatic take();
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        tick();
        eoi_valid = 1'b0;
    endtask

    // ---------------- directed and random scenarios ----------------
    initial begin
        logic [31:0] v;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R3 reset state, R1 identity/version/arbitration, R2 layout
        check("R3 no message after reset", {31'b0, msg_valid}, 32'h0);
        rd_entry(0, 0, v);   check("R3 entry 0 low reset", v, 32'h0001_0000);
        rd_entry(23, 1, v);  check("R3 entry 23 high reset", v, 32'h0);
        rd_index(8'h01, 8'h10, v); check("R1 version word", v, 32'h0017_0011);
        wr(8'h00, 8'h00); wr(8'h10, 32'hFA00_0000);
        rd_index(8'h00, 8'h10, v); check("R1 identity word", v, 32'h0A00_0000);
        rd_index(8'h02, 8'h10, v); check("R1 arbitration word", v, 32'h0A00_0000);
        wr(8'h00, 8'h01); wr(8'h10, 32'hFFFF_FFFF);
        rd_index(8'h01, 8'h10, v); check("R1 version read-only", v, 32'h0017_0011);
        rd_index(8'h05, 8'h20, v); check("R1 unused offset", v, 32'h0);
        wr_entry(4, 0, 32'hFFFF_FFFF);
        rd_entry(4, 0, v);   check("R2 low word fields", v, 32'h0001_AFFF);
        wr_entry(4, 0, 32'h0001_0000);
        wr_entry(4, 1, 32'hFFFF_FFFF);
        rd_entry(4, 1, v);   check("R2 high word fields", v, 32'hFF00_0000);
        wr_entry(4, 1, 32'h0);
        rd_index(8'h40, 8'h10, v); check("R2 index past last entry", v, 32'h0);
        rd_index(8'h05, 8'h10, v); check("R2 unused low index", v, 32'h0);

        // R4/R5 edge delivery
        wr_entry(3, 1, 32'h5A00_0000);
        wr_entry(3, 0, 32'h0000_0043);
        irq_pin[3] = 1'b1;
        tick(5);
        @(negedge clk);
        check("R4 edge message", {msg_valid, msg_level, msg_dest, msg_vector}, {1'b1, 1'b0, 8'h5A, 8'h43});
        tick();
        rd_entry(3, 0, v);   check("R5 status while waiting", {31'b0, v[12]}, 32'h1);
        take();
        peek_valid("R5 message gone after handshake", 1'b0);
        rd_entry(3, 0, v);   check("R5 status after handshake", {31'b0, v[12]}, 32'h0);
        tick(5);
        peek_valid("R4 held edge pin not resent", 1'b0);
        irq_pin[3] = 1'b0;

        // R6 priority
        wr_entry(1, 0, 32'h0000_0031);
        wr_entry(5, 0, 32'h0000_0035);
        irq_pin[1] = 1'b1; irq_pin[5] = 1'b1;
        tick(5);
        peek_msg("R6 lowest entry first", 8'h31, 1'b0);
        take();
        peek_msg("R6 next entry second", 8'h35, 1'b0);
        take();
        peek_valid("R6 all taken", 1'b0);
        irq_pin[1] = 1'b0; irq_pin[5] = 1'b0;
        tick(4);

        // R7 masking
        wr_entry(5, 0, 32'h0001_0035);
        tick(3);
        irq_pin[5] = 1'b1;
        tick(5);
        wr_entry(5, 0, 32'h0000_0035);
        tick(5);
        peek_valid("R7 masked edge lost", 1'b0);
        irq_pin[5] = 1'b0;
        irq_pin[1] = 1'b1;
        tick(5);
        rd_entry(1, 0, v);   check("R7 pending before mask", {31'b0, v[12]}, 32'h1);
        wr_entry(1, 0, 32'h0001_0031);
        tick(2);
        peek_valid("R7 mask cancels request", 1'b0);
        rd_entry(1, 0, v);   check("R7 status cleared by mask", {31'b0, v[12]}, 32'h0);
        wr_entry(1, 0, 32'h0000_0031);
        tick(5);
        peek_valid("R7 cancelled edge not revived", 1'b0);
        irq_pin[1] = 1'b0;

        // R4 polarity
        wr_entry(7, 0, 32'h0001_2047);
        tick(4);
        wr_entry(7, 0, 32'h0000_2047);
        tick(5);
        peek_valid("R4 idle active-low pin quiet", 1'b0);
        irq_pin[7] = 1'b1;
        tick(4);
        irq_pin[7] = 1'b0;
        tick(5);
        peek_msg("R4 active-low falling pin delivers", 8'h47, 1'b0);
        take();

        // R8/R9/R10 level handshake
        wr_entry(9, 0, 32'h0000_8059);
        irq_pin[9] = 1'b1;
        tick(5);
        peek_msg("R8 level message", 8'h59, 1'b1);
        take();
        peek_valid("R8 taken", 1'b0);
        rd_entry(9, 0, v);   check("R8 remote IRR set", {31'b0, v[14]}, 32'h1);
        tick(5);
        peek_valid("R8 blocked while awaiting EOI", 1'b0);
        eoi(8'h58);
        rd_entry(9, 0, v);   check("R9 other vector ignored", {31'b0, v[14]}, 32'h1);
        eoi(8'h59);
        tick(3);
        peek_msg("R10 redelivered after EOI", 8'h59, 1'b1);
        take();
        rd_entry(9, 0, v);   check("R10 remote IRR set again", {31'b0, v[14]}, 32'h1);
        eoi(8'h59);
        tick(3);
        irq_pin[9] = 1'b0;
        tick(4);
        peek_valid("R8 withdrawn when pin drops", 1'b0);
        rd_entry(9, 0, v);   check("R8 idle after withdrawal", {30'b0, v[14], v[12]}, 32'h0);

        // R9 shared vector
        wr_entry(10, 0, 32'h0000_8060);
        wr_entry(11, 0, 32'h0000_8060);
        irq_pin[10] = 1'b1; irq_pin[11] = 1'b1;
        tick(5);
        take();
        take();
        irq_pin[10] = 1'b0; irq_pin[11] = 1'b0;
        tick(4);
        rd_entry(10, 0, v);  check("R9 entry 10 awaiting", {31'b0, v[14]}, 32'h1);
        rd_entry(11, 0, v);  check("R9 entry 11 awaiting", {31'b0, v[14]}, 32'h1);
        eoi(8'h60);
        rd_entry(10, 0, v);  check("R9 entry 10 cleared", {31'b0, v[14]}, 32'h0);
        rd_entry(11, 0, v);  check("R9 entry 11 cleared", {31'b0, v[14]}, 32'h0);

        // R11 NMI forced edge
        wr_entry(12, 0, 32'h0000_8470);
        irq_pin[12] = 1'b1;
        tick(5);
        @(negedge clk);
        check("R11 NMI message edge", {msg_valid, msg_level, 5'b0, msg_mode}, {1'b1, 1'b0, 5'b0, 3'b100});
        tick();
        take();
        rd_entry(12, 0, v);  check("R11 no remote IRR", {31'b0, v[14]}, 32'h0);
        tick(5);
        peek_valid("R11 held pin not resent", 1'b0);
        irq_pin[12] = 1'b0;

        // R12 EOI together with the grant
        wr_entry(13, 0, 32'h0000_8077);
        irq_pin[13] = 1'b1;
        tick(5);
        msg_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h77;
        tick();
        msg_ready = 1'b0; eoi_valid = 1'b0;
        rd_entry(13, 0, v);  check("R12 same-cycle EOI does not clear", {31'b0, v[14]}, 32'h1);
        irq_pin[13] = 1'b0;
        eoi(8'h77);
        tick(3);

        // random phase, judged by the per-clock model comparison
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8) irq_pin[$urandom_range(0, NP - 1)] ^= 1'b1;
            msg_ready  = ($urandom_range(0, 3) != 0);
            eoi_valid  = ($urandom_range(0, 5) == 0);
            case ($urandom_range(0, 3))
                0: eoi_vector = 8'h59;
                1: eoi_vector = 8'h60;
                2: eoi_vector = 8'h77;
                default: eoi_vector = 8'($urandom_range(0, 255));
            endcase
            acc_wr = 1'b0;
            acc_addr = ($urandom_range(0, 1) != 0) ? 8'h10 : 8'h00;
            if (r >= 90) begin
                acc_wr = 1'b1;
                if (acc_addr == 8'h00) acc_wdata = 32'($urandom_range(0, 8'h3F));
                else begin
                    acc_wdata = $urandom;
                    acc_wdata[7:0] = ($urandom_range(0, 1) != 0) ? 8'h60 : 8'h59;
                end
            end
            tick();
        end
        acc_wr = 1'b0; msg_ready = 1'b0; eoi_valid = 1'b0;
        tick(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule